// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the fetch address of a small 8-bit RISC core whose program space is 2K words of 13-bit instructions, so the address is 11 bits wide. Each enabled instruction cycle it either steps the address by one or redirects it. A redirect comes from an absolute jump or call, a return, a hardware or software interrupt, or a register-file write to the low address byte. Absolute branch targets carry only 10 bits. The page bit on top of them comes from a separately written 3-bit page buffer. A five-deep hardware stack saves full 11-bit return addresses, so returns never consult the page buffer.

The core drives one-cycle decoded strobes together with a 10-bit target and the register-file write data. It reads the low address byte and the page buffer back as two data-memory-mapped registers. Every redirect costs two instruction cycles. In the cycle after a redirect the block raises `bubble`, holds the address and ignores every strobe, so the core can discard the instruction fetched in that slot.

Top module: `prog_ctr_top`

## Requirements
- R1: During and straight after reset, `fetch_addr` is 7FFh, `hi_rd` is 00h, `lo_rd` is FFh, `bubble` is 0 and the return stack is empty.
- R2: In an enabled cycle (`ce`=1, `bubble`=0) with no strobe, `fetch_addr` advances by one and wraps from 7FFh to 000h. With `ce`=0 the address, the page buffer, the stack and `bubble` all hold.
- R3: `do_jump` loads `fetch_addr` with bit 2 of the page buffer as bit 10 and `tgt` as bits 9..0. The page buffer value used is the one held before any `wr_hi` in the same cycle.
- R4: `do_call` pushes the address plus one onto the stack and loads the same paged target as R3.
- R5: `do_ret` loads `fetch_addr` with the 11-bit value on top of the stack, whatever the page buffer holds.
- R6: `hw_irq` pushes the current address unchanged and loads 008h. `sw_irq` pushes the address plus one and loads 002h. Strobe priority, from highest to lowest, is `hw_irq`, `sw_irq`, `do_ret`, `do_call`, `do_jump`, `wr_lo`.
- R7: `wr_lo` loads `fetch_addr` with the page buffer as bits 10..8 and `wr_data` as bits 7..0.
- R8: `wr_hi` stores `wr_data[2:0]` in the page buffer. `hi_rd` reads the buffer in bits 2..0 with bits 7..3 as 0, and `lo_rd` reads `fetch_addr[7:0]`.
- R9: Every redirect (R3 to R7) sets `bubble` for the next enabled cycle. In that cycle the address holds and all strobes, `wr_hi` included, have no effect. After it, `bubble` clears.
- R10: A push onto a stack holding five entries drops the oldest one. The five newest entries then return in reverse push order.
- R11: A return on an empty stack loads the value returned by the most recent successful pop, or 000h if none has occurred since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Instruction-cycle enable |
| hw_irq | input | 1 | Hardware interrupt entry strobe |
| sw_irq | input | 1 | Software interrupt instruction strobe |
| do_ret | input | 1 | Return strobe |
| do_call | input | 1 | Call strobe |
| do_jump | input | 1 | Jump strobe |
| tgt | input | 10 | In-page branch target |
| wr_lo | input | 1 | Write strobe for the low address byte register |
| wr_hi | input | 1 | Write strobe for the page buffer register |
| wr_data | input | 8 | Register-file write data |
| fetch_addr | output | 11 | Current fetch address |
| lo_rd | output | 8 | Read value of the low address byte register |
| hi_rd | output | 8 | Read value of the page buffer register |
| bubble | output | 1 | Discard slot following a redirect |

## Verification
The assertions assume that `ce` is a clean level and that the strobes are settled at each rising edge. They do not assume the strobes are one-hot. Several are raised together on purpose to exercise the priority order, and the assertions restate that order in their antecedents. The stimulus holds strobes high through bubble slots and runs the stack past both full and empty, so the ignore, overflow and underflow rules are checked at the ports. Every drive happens just after a rising edge, and every comparison happens at the falling edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_HWV,
        SEL_SWV,
        SEL_POP,
        SEL_BR,
        SEL_LOW
    } pc_sel_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP
    } stk_op_e;

endpackage

// File: rtl/pcs_sel.sv
module pcs_sel
    import pcs_pkg::*;
(
    input  logic    ce,
    input  logic    bubble,
    input  logic    hw_irq,
    input  logic    sw_irq,
    input  logic    do_ret,
    input  logic    do_call,
    input  logic    do_jump,
    input  logic    wr_lo,
    input  logic    wr_hi,
    output pc_sel_e sel,
    output stk_op_e op,
    output logic    redirect,
    output logic    buf_we
);

    always_comb begin
        sel      = SEL_HOLD;
        op       = OP_NONE;
        redirect = 1'b0;
        buf_we   = 1'b0;
        if (ce && !bubble) begin
            buf_we   = wr_hi;
            redirect = 1'b1;
            if (hw_irq) begin
                sel = SEL_HWV;
                op  = OP_PUSH;
            end else if (sw_irq) begin
                sel = SEL_SWV;
                op  = OP_PUSH;
            end else if (do_ret) begin
                sel = SEL_POP;
                op  = OP_POP;
            end else if (do_call) begin
                sel = SEL_BR;
                op  = OP_PUSH;
            end else if (do_jump) begin
                sel = SEL_BR;
            end else if (wr_lo) begin
                sel = SEL_LOW;
            end else begin
                sel      = SEL_INC;
                redirect = 1'b0;
            end
        end
    end

endmodule

// File: rtl/pcs_stack.sv
module pcs_stack
    import pcs_pkg::*;
#(
    parameter int unsigned AW    = 11,
    parameter int unsigned DEPTH = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top_val
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [CW-1:0]            cnt;
        logic [AW-1:0]            last;
    } stk_t;

    stk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (op)
            OP_PUSH: begin
                for (int i = DEPTH - 1; i > 0; i--) begin
                    s_d.ent[i] = s_q.ent[i-1];
                end
                s_d.ent[0] = push_val;
                if (s_q.cnt != CW'(DEPTH)) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            OP_POP: begin
                if (s_q.cnt != '0) begin
                    for (int i = 0; i < DEPTH - 1; i++) begin
                        s_d.ent[i] = s_q.ent[i+1];
                    end
                    s_d.ent[DEPTH-1] = '0;
                    s_d.last         = s_q.ent[0];
                    s_d.cnt          = s_q.cnt - 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign top_val = (s_q.cnt == '0) ? s_q.last : s_q.ent[0];

endmodule

// File: rtl/prog_ctr_top.sv
module prog_ctr_top
    import pcs_pkg::*;
#(
    parameter int unsigned AW     = 11,
    parameter int unsigned TW     = 10,
    parameter int unsigned DW     = 8,
    parameter int unsigned DEPTH  = 5,
    parameter logic [10:0] RST_VEC = 11'h7FF,
    parameter logic [10:0] HW_VEC  = 11'h008,
    parameter logic [10:0] SW_VEC  = 11'h002
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          hw_irq,
    input  logic          sw_irq,
    input  logic          do_ret,
    input  logic          do_call,
    input  logic          do_jump,
    input  logic [TW-1:0] tgt,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wr_data,
    output logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] lo_rd,
    output logic [DW-1:0] hi_rd,
    output logic          bubble
);

    localparam int unsigned HBW = AW - DW;
    localparam int unsigned PGW = AW - TW;

    typedef struct packed {
        logic [AW-1:0]  pc;
        logic [HBW-1:0] hbuf;
        logic           bub;
    } pc_st_t;

    pc_st_t  st_d, st_q;
    pc_sel_e sel;
    stk_op_e op;
    logic    redirect;
    logic    buf_we;
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] push_val;
    logic [AW-1:0] pop_val;

    pcs_sel sel_i (
        .ce       (ce),
        .bubble   (st_q.bub),
        .hw_irq   (hw_irq),
        .sw_irq   (sw_irq),
        .do_ret   (do_ret),
        .do_call  (do_call),
        .do_jump  (do_jump),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .sel      (sel),
        .op       (op),
        .redirect (redirect),
        .buf_we   (buf_we)
    );

    assign pc_inc   = st_q.pc + 1'b1;
    assign push_val = (sel == SEL_HWV) ? st_q.pc : pc_inc;

    pcs_stack #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) stack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .push_val (push_val),
        .top_val  (pop_val)
    );

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.bub = redirect;
            case (sel)
                SEL_INC: st_d.pc = pc_inc;
                SEL_HWV: st_d.pc = AW'(HW_VEC);
                SEL_SWV: st_d.pc = AW'(SW_VEC);
                SEL_POP: st_d.pc = pop_val;
                SEL_BR:  st_d.pc = {st_q.hbuf[HBW-1 -: PGW], tgt};
                SEL_LOW: st_d.pc = {st_q.hbuf, wr_data};
                default: st_d.pc = st_q.pc;
            endcase
            if (buf_we) begin
                st_d.hbuf = wr_data[HBW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc   <= AW'(RST_VEC);
            st_q.hbuf <= '0;
            st_q.bub  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = st_q.pc;
    assign lo_rd      = st_q.pc[DW-1:0];
    assign hi_rd      = {{(DW-HBW){1'b0}}, st_q.hbuf};
    assign bubble     = st_q.bub;

endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
    parameter int unsigned AW = 11,
    parameter int unsigned TW = 10,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce,
    input logic          hw_irq,
    input logic          sw_irq,
    input logic          do_ret,
    input logic          do_call,
    input logic          do_jump,
    input logic [TW-1:0] tgt,
    input logic          wr_lo,
    input logic          wr_hi,
    input logic [DW-1:0] wr_data,
    input logic [AW-1:0] fetch_addr,
    input logic [DW-1:0] hi_rd,
    input logic          bubble
);

    localparam int unsigned HBW = AW - DW;

    logic live;
    logic any_redir;
    assign live      = ce && !bubble;
    assign any_redir = hw_irq || sw_irq || do_ret || do_call || do_jump || wr_lo;

    // R2
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !any_redir) |=> fetch_addr == AW'($past(fetch_addr) + 1'b1));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(fetch_addr) && $stable(hi_rd) && $stable(bubble)));

    // R3
    jump_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && do_jump && !hw_irq && !sw_irq && !do_ret && !do_call)
        |=> fetch_addr[TW-1:0] == $past(tgt));

    // R6
    hw_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && hw_irq) |=> fetch_addr == AW'(11'h008));

    // R6
    sw_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !hw_irq && sw_irq) |=> fetch_addr == AW'(11'h002));

    // R8
    page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wr_hi) |=> hi_rd[HBW-1:0] == $past(wr_data[HBW-1:0]));

    // R9
    bubble_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && any_redir) |=> bubble);

    // R9
    bubble_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && bubble) |=> (!bubble && $stable(fetch_addr) && $stable(hi_rd)));

endmodule

bind prog_ctr_top pcs_chk #(
    .AW (AW),
    .TW (TW),
    .DW (DW)
) chk_i (.*);

// File: tb/prog_ctr_top_tb_top.sv
module prog_ctr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b1;
    logic        hw_irq = 1'b0, sw_irq = 1'b0, do_ret = 1'b0, do_call = 1'b0, do_jump = 1'b0;
    logic [9:0]  tgt = '0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [10:0] fetch_addr;
    logic [7:0]  lo_rd, hi_rd;
    logic        bubble;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prog_ctr_top dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .hw_irq(hw_irq), .sw_irq(sw_irq),
        .do_ret(do_ret), .do_call(do_call), .do_jump(do_jump), .tgt(tgt),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .fetch_addr(fetch_addr), .lo_rd(lo_rd), .hi_rd(hi_rd), .bubble(bubble)
    );

    typedef struct {
        logic [10:0] pc;
        logic [7:0]  hi;
        logic        bub;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // reference state
    logic [10:0] m_pc   = 11'h7FF;
    logic [2:0]  m_buf  = 3'd0;
    logic        m_bub  = 1'b0;
    logic [10:0] m_last = 11'h000;
    logic [10:0] m_stk[$];

    task automatic m_push(input logic [10:0] v);
        m_stk.push_front(v);
        if (m_stk.size() > 5) void'(m_stk.pop_back());
    endtask

    function automatic logic [10:0] m_pop();
        if (m_stk.size() != 0) m_last = m_stk.pop_front();
        return m_last;
    endfunction

    task automatic clr();
        ce = 1'b1; hw_irq = 0; sw_irq = 0; do_ret = 0; do_call = 0;
        do_jump = 0; wr_lo = 0; wr_hi = 0;
    endtask

    // driver: apply current inputs for one cycle and queue the expected result
    task automatic tick(input string tag);
        exp_t e;
        logic [2:0] old_buf;
        old_buf = m_buf;
        if (ce) begin
            if (m_bub) begin
                m_bub = 1'b0;
            end else begin
                m_bub = 1'b1;
                if (hw_irq) begin
                    m_push(m_pc); m_pc = 11'h008;
                end else if (sw_irq) begin
                    m_push(m_pc + 11'd1); m_pc = 11'h002;
                end else if (do_ret) begin
                    m_pc = m_pop();
                end else if (do_call) begin
                    m_push(m_pc + 11'd1); m_pc = {old_buf[2], tgt};
                end else if (do_jump) begin
                    m_pc = {old_buf[2], tgt};
                end else if (wr_lo) begin
                    m_pc = {old_buf, wr_data};
                end else begin
                    m_pc = m_pc + 11'd1; m_bub = 1'b0;
                end
                if (wr_hi) m_buf = wr_data[2:0];
            end
        end
        @(posedge clk);
        #1;
        e.pc = m_pc; e.hi = {5'b0, m_buf}; e.bub = m_bub; e.tag = tag;
        sb.push_back(e);
        clr();
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (fetch_addr !== e.pc || hi_rd !== e.hi || bubble !== e.bub || lo_rd !== e.pc[7:0]) begin
                errors++;
                $display("FAIL %s: addr=%h hi=%h lo=%h bub=%b expected addr=%h hi=%h lo=%h bub=%b",
                         e.tag, fetch_addr, hi_rd, lo_rd, bubble, e.pc, e.hi, e.pc[7:0], e.bub);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (fetch_addr !== 11'h7FF || hi_rd !== 8'h00 || lo_rd !== 8'hFF || bubble !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: addr=%h hi=%h lo=%h bub=%b expected 7ff 00 ff 0",
                     fetch_addr, hi_rd, lo_rd, bubble);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: wrap and stepping, then hold with ce low
        tick("R2 wrap");
        tick("R2 step");
        tick("R2 step");
        ce = 0; do_jump = 1; tgt = 10'h155; tick("R2 ce low hold");
        ce = 0; tick("R2 ce low hold");

        // R8 and R3: page buffer then paged jump, R9 bubble ignores strobes
        wr_hi = 1; wr_data = 8'hFC; tick("R8 page write");
        do_jump = 1; tgt = 10'h3A5; tick("R3 paged jump");
        do_jump = 1; tgt = 10'h011; wr_hi = 1; wr_data = 8'h01; tick("R9 bubble ignores");
        tick("R9 after bubble");
        wr_hi = 1; wr_data = 8'h00; do_jump = 1; tgt = 10'h0C0; tick("R3 old page used");
        ce = 0; tick("R9 bubble held with ce low");
        tick("R9 bubble slot");

        // R4 call / R5 return ignoring page buffer
        do_call = 1; tgt = 10'h100; tick("R4 call");
        tick("R4 bubble");
        tick("R4 step");
        wr_hi = 1; wr_data = 8'h04; tick("R8 page write");
        do_ret = 1; tick("R5 return");
        tick("R5 bubble");

        // R7 low byte write
        wr_hi = 1; wr_data = 8'h03; tick("R8 page write 3");
        wr_lo = 1; wr_data = 8'h5A; tick("R7 low write");
        tick("R7 bubble");

        // R6 priority and vectors
        hw_irq = 1; sw_irq = 1; do_call = 1; do_ret = 1; tgt = 10'h2AA; tick("R6 hw wins");
        tick("R6 bubble");
        sw_irq = 1; do_call = 1; do_jump = 1; tgt = 10'h077; tick("R6 sw vector");
        tick("R6 bubble");
        do_ret = 1; do_call = 1; tgt = 10'h3FF; tick("R6 ret over call");
        tick("R6 bubble");
        do_ret = 1; tick("R5 return to hw point");
        tick("R5 bubble");
        do_jump = 1; wr_lo = 1; wr_data = 8'h10; tgt = 10'h222; tick("R6 jump over wr_lo");
        tick("R6 bubble");

        // R10: six calls overflow the five-entry stack
        for (int i = 0; i < 6; i++) begin
            do_call = 1; tgt = 10'(10'h040 + i * 16); tick("R10 call push");
            tick("R10 bubble");
            tick("R10 step");
        end
        for (int i = 0; i < 5; i++) begin
            do_ret = 1; tick("R10 return order");
            tick("R10 bubble");
        end

        // R11: pops on empty stack repeat the last popped value
        tick("R11 step");
        do_ret = 1; tick("R11 empty pop");
        tick("R11 bubble");
        tick("R11 step");
        do_ret = 1; tick("R11 empty pop again");
        tick("R11 bubble");

        // R2 wrap from a low write near the top
        wr_hi = 1; wr_data = 8'h07; tick("R8 page write 7");
        wr_lo = 1; wr_data = 8'hFE; tick("R7 low write 7fe");
        tick("R7 bubble");
        tick("R2 to 7ff");
        tick("R2 wrap 000");

        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule